// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor with seven operating modes, along with the saved-status registers of its exception modes. The caller supplies a register number and the current mode, and the block selects the physical copy that belongs to that pair. Low registers and register 15 have a single copy. The fast-interrupt mode shadows registers 8 to 14. The other four exception modes each shadow only registers 13 and 14. System mode uses the user copies.

There are two combinational read ports and one write port that takes effect at the clock edge. A separate port reads and writes the saved-status register of the current mode. A user-bank override input makes the general-register ports use the user copies whatever the current mode is. Exception handlers use it to reach user-mode state.

Top module: `banked_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every general register copy and every saved-status register to zero.
- R2: Reads are combinational. A write with `wr_en_i` high lands at the rising clock edge. A read of the register being written in that same cycle returns the old value. With `wr_en_i` low, no register changes.
- R3: Registers 0 to 7 and register 15 have one copy, seen and written identically from every mode.
- R4: Fast-interrupt mode (mode code 5'b10001) has private copies of registers 8 to 14, separate from the user copies.
- R5: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private copies of registers 13 and 14. For registers 8 to 12 they use the user copies.
- R6: System mode (5'b11111) reads and writes exactly the user-mode (5'b10000) copies.
- R7: With `user_ovr_i` high, both read ports and the write port use the user copies, in any mode.
- R8: Each of the five exception modes has one saved-status register, reached through the status port in that mode. `user_ovr_i` has no effect on which saved-status register is selected.
- R9: In user or system mode, the status port reads zero and a status write changes no saved-status register.
- R10: A mode code other than the seven listed behaves as user mode for both the general registers and the status port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current mode code |
| user_ovr_i | input | 1 | Force user copies on general-register ports |
| rd_a_idx_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General-register write enable |
| wr_idx_i | input | 4 | Write register number |
| wr_data_i | input | 32 | Write data |
| sts_wr_en_i | input | 1 | Saved-status write enable |
| sts_wr_data_i | input | 32 | Saved-status write data |
| sts_rd_data_o | output | 32 | Saved-status read data for the current mode |

## Verification
The hardest condition to reach is one where distinct physical copies of the same register number hold distinct values at the same time. Only then does a wrong bank choice show up at the read ports. The stimulus first fills registers 8 to 14 with one signature in user mode and another in fast-interrupt mode. It then gives registers 13 and 14 a per-mode signature in each of the other exception modes. Only after that are the cross-mode reads, system-mode aliasing and override accesses made, so every mis-steered access returns a value that differs from the expected one. Saved-status registers are loaded with per-mode values in the same way before the user-mode and system-mode writes that must be ignored.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;

    localparam int ARCH_REGS   = 16;
    localparam int ARCH_W      = $clog2(ARCH_REGS);
    localparam int FIQ_SHADOW  = 7;
    localparam int EXC_MODES   = 4;
    localparam int EXC_SHADOW  = 2;
    localparam int FIQ_BASE    = ARCH_REGS;
    localparam int EXC_BASE    = FIQ_BASE + FIQ_SHADOW;
    localparam int PHYS_REGS   = EXC_BASE + EXC_MODES * EXC_SHADOW;
    localparam int PHYS_W      = $clog2(PHYS_REGS);
    localparam int SAVED_BANKS = EXC_MODES + 1;
    localparam int SAVED_W     = $clog2(SAVED_BANKS);

    localparam logic [ARCH_W-1:0] FIQ_LO_IDX = ARCH_W'(8);
    localparam logic [ARCH_W-1:0] EXC_LO_IDX = ARCH_W'(13);
    localparam logic [ARCH_W-1:0] BANK_HI_IDX = ARCH_W'(14);

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    function automatic bank_e mode_to_bank(input logic [4:0] m);
        bank_e b;
        case (m)
            MODE_FIQ: b = BANK_FIQ;
            MODE_IRQ: b = BANK_IRQ;
            MODE_SVC: b = BANK_SVC;
            MODE_ABT: b = BANK_ABT;
            MODE_UND: b = BANK_UND;
            default:  b = BANK_USR;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bkrf_bank_decode.sv
module bkrf_bank_decode
    import bkrf_pkg::*;
(
    input  logic [4:0]         mode_i,
    input  logic               user_ovr_i,
    output bank_e              gpr_bank_o,
    output logic               sts_valid_o,
    output logic [SAVED_W-1:0] sts_sel_o
);
    bank_e mode_bank;

    always_comb begin
        mode_bank   = mode_to_bank(mode_i);
        gpr_bank_o  = user_ovr_i ? BANK_USR : mode_bank;
        sts_valid_o = (mode_bank != BANK_USR);
        sts_sel_o   = '0;
        if (mode_bank != BANK_USR) begin
            sts_sel_o = SAVED_W'(int'(mode_bank) - int'(BANK_FIQ));
        end
    end
endmodule

// File: rtl/bkrf_map.sv
module bkrf_map
    import bkrf_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [ARCH_W-1:0] arch_i,
    output logic [PHYS_W-1:0] phys_o
);
    logic fiq_hit;
    logic exc_bank;
    logic exc_hit;

    always_comb begin
        fiq_hit  = (bank_i == BANK_FIQ) &&
                   (arch_i >= FIQ_LO_IDX) && (arch_i <= BANK_HI_IDX);
        exc_bank = (bank_i == BANK_IRQ) || (bank_i == BANK_SVC) ||
                   (bank_i == BANK_ABT) || (bank_i == BANK_UND);
        exc_hit  = exc_bank &&
                   (arch_i >= EXC_LO_IDX) && (arch_i <= BANK_HI_IDX);
        phys_o   = PHYS_W'(arch_i);
        if (fiq_hit) begin
            phys_o = PHYS_W'(FIQ_BASE + int'(arch_i) - int'(FIQ_LO_IDX));
        end else if (exc_hit) begin
            phys_o = PHYS_W'(EXC_BASE
                             + EXC_SHADOW * (int'(bank_i) - int'(BANK_IRQ))
                             + int'(arch_i) - int'(EXC_LO_IDX));
        end
    end
endmodule

// File: rtl/bkrf_gpr_store.sv
module bkrf_gpr_store
    import bkrf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RD_PORTS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [PHYS_W-1:0]              wr_phys_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic [RD_PORTS-1:0][PHYS_W-1:0] rd_phys_i,
    output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [PHYS_REGS-1:0][DATA_W-1:0] r;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (wr_phys_i < PHYS_W'(PHYS_REGS))) begin
            st_d.r[wr_phys_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            rd_data_o[p] = '0;
            if (rd_phys_i[p] < PHYS_W'(PHYS_REGS)) begin
                rd_data_o[p] = st_q.r[rd_phys_i[p]];
            end
        end
    end
endmodule

// File: rtl/bkrf_saved_store.sv
module bkrf_saved_store
    import bkrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [SAVED_W-1:0] sel_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o
);
    typedef struct packed {
        logic [SAVED_BANKS-1:0][DATA_W-1:0] s;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic       sel_ok;

    always_comb begin
        sel_ok = valid_i && (sel_i < SAVED_W'(SAVED_BANKS));
        st_d   = st_q;
        if (wr_en_i && sel_ok) begin
            st_d.s[sel_i] = wr_data_i;
        end
        rd_data_o = sel_ok ? st_q.s[sel_i] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bkrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              user_ovr_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sts_wr_en_i,
    input  logic [DATA_W-1:0] sts_wr_data_i,
    output logic [DATA_W-1:0] sts_rd_data_o
);
    localparam int N_MAP   = 3;
    localparam int RD_N    = 2;
    localparam int WR_SLOT = RD_N;

    bank_e                           gpr_bank;
    logic                            sts_valid;
    logic [SAVED_W-1:0]              sts_sel;
    logic [N_MAP-1:0][ARCH_W-1:0]    arch_sel;
    logic [N_MAP-1:0][PHYS_W-1:0]    phys_sel;
    logic [RD_N-1:0][DATA_W-1:0]     rd_data;

    bkrf_bank_decode u_decode (
        .mode_i      (mode_i),
        .user_ovr_i  (user_ovr_i),
        .gpr_bank_o  (gpr_bank),
        .sts_valid_o (sts_valid),
        .sts_sel_o   (sts_sel)
    );

    always_comb begin
        arch_sel[0]       = rd_a_idx_i;
        arch_sel[1]       = rd_b_idx_i;
        arch_sel[WR_SLOT] = wr_idx_i;
    end

    for (genvar k = 0; k < N_MAP; k++) begin : g_map
        bkrf_map u_map (
            .bank_i (gpr_bank),
            .arch_i (arch_sel[k]),
            .phys_o (phys_sel[k])
        );
    end

    bkrf_gpr_store #(
        .DATA_W   (DATA_W),
        .RD_PORTS (RD_N)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_phys_i (phys_sel[WR_SLOT]),
        .wr_data_i (wr_data_i),
        .rd_phys_i (phys_sel[RD_N-1:0]),
        .rd_data_o (rd_data)
    );

    bkrf_saved_store #(
        .DATA_W (DATA_W)
    ) u_saved (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (sts_valid),
        .sel_i     (sts_sel),
        .wr_en_i   (sts_wr_en_i),
        .wr_data_i (sts_wr_data_i),
        .rd_data_o (sts_rd_data_o)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/bkrf_checker.sv
module bkrf_checker
    import bkrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              user_ovr_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              sts_wr_en_i,
    input logic [DATA_W-1:0] sts_wr_data_i,
    input logic [DATA_W-1:0] sts_rd_data_o
);
    logic a_shared;
    logic exc_mode;
    logic plain_mode;

    always_comb begin
        a_shared   = (rd_a_idx_i < 4'd8) || (rd_a_idx_i == 4'd15);
        exc_mode   = (mode_i == MODE_FIQ) || (mode_i == MODE_IRQ) ||
                     (mode_i == MODE_SVC) || (mode_i == MODE_ABT) ||
                     (mode_i == MODE_UND);
        plain_mode = (mode_i == MODE_USR) || (mode_i == MODE_SYS);
    end

    // R1: outputs read zero while reset is held
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            assert_reset_clear_R1: assert (rd_a_data_o == '0 &&
                                           rd_b_data_o == '0 &&
                                           sts_rd_data_o == '0)
                else $error("reset state not zero");
        end
    end

    // R2: a written value is visible on the next cycle at the same mapping
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && rd_b_idx_i == $past(wr_idx_i) &&
         mode_i == $past(mode_i) && user_ovr_i == $past(user_ovr_i))
        |-> rd_b_data_o == $past(wr_data_i));

    // R2: without a write, a steady read selection keeps its value
    assert_read_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && $stable(rd_a_idx_i) && $stable(mode_i) &&
         $stable(user_ovr_i))
        |-> $stable(rd_a_data_o));

    // R3: shared registers do not change with the mode alone
    assert_shared_mode_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_shared && !$past(wr_en_i) && $stable(rd_a_idx_i))
        |-> $stable(rd_a_data_o));

    // R8: a saved-status write is read back next cycle in the same mode
    assert_saved_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sts_wr_en_i) && exc_mode &&
         mode_i == $past(mode_i))
        |-> sts_rd_data_o == $past(sts_wr_data_i));

    // R9: user and system modes see no saved-status register
    assert_plain_mode_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        plain_mode |-> sts_rd_data_o == '0);
endmodule

bind banked_regfile bkrf_checker #(.DATA_W(DATA_W)) u_bkrf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .user_ovr_i    (user_ovr_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_idx_i    (rd_b_idx_i),
    .rd_b_data_o   (rd_b_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .sts_wr_en_i   (sts_wr_en_i),
    .sts_wr_data_i (sts_wr_data_i),
    .sts_rd_data_o (sts_rd_data_o)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = M_USR;
    logic        ovr = 1'b0;
    logic [3:0]  ra = '0;
    logic [3:0]  rb = '0;
    logic        wen = 1'b0;
    logic [3:0]  widx = '0;
    logic [31:0] wdat = '0;
    logic        swen = 1'b0;
    logic [31:0] swdat = '0;
    logic [31:0] rda, rdb, srd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .user_ovr_i    (ovr),
        .rd_a_idx_i    (ra),
        .rd_a_data_o   (rda),
        .rd_b_idx_i    (rb),
        .rd_b_data_o   (rdb),
        .wr_en_i       (wen),
        .wr_idx_i      (widx),
        .wr_data_i     (wdat),
        .sts_wr_en_i   (swen),
        .sts_wr_data_i (swdat),
        .sts_rd_data_o (srd)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [4:0] m, input logic o, input logic [3:0] idx,
                       input logic [31:0] d);
        @(negedge clk);
        mode = m; ovr = o; widx = idx; wdat = d; wen = 1'b1; swen = 1'b0;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic look(input logic [4:0] m, input logic o, input logic [3:0] idx,
                        input logic [31:0] exp, input string tag);
        @(negedge clk);
        mode = m; ovr = o; ra = idx; rb = idx; wen = 1'b0; swen = 1'b0;
        #1;
        chk(rda, exp, {tag, " portA"});
        chk(rdb, exp, {tag, " portB"});
    endtask

    task automatic put_sts(input logic [4:0] m, input logic o, input logic [31:0] d);
        @(negedge clk);
        mode = m; ovr = o; swdat = d; swen = 1'b1; wen = 1'b0;
        @(negedge clk);
        swen = 1'b0;
    endtask

    task automatic look_sts(input logic [4:0] m, input logic o, input logic [31:0] exp,
                            input string tag);
        @(negedge clk);
        mode = m; ovr = o; swen = 1'b0; wen = 1'b0;
        #1;
        chk(srd, exp, tag);
    endtask

    function automatic logic [4:0] exc_mode(input int j);
        case (j)
            1:       return M_IRQ;
            2:       return M_SVC;
            3:       return M_ABT;
            default: return M_UND;
        endcase
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 16; i++) look(M_USR, 1'b0, 4'(i), 32'h0, "R1 user reg after reset");
        look(M_FIQ, 1'b0, 4'd10, 32'h0, "R1 fiq r10 after reset");
        look(M_UND, 1'b0, 4'd14, 32'h0, "R1 und r14 after reset");
        look_sts(M_FIQ, 1'b0, 32'h0, "R1 fiq status after reset");
        look_sts(M_SVC, 1'b0, 32'h0, "R1 svc status after reset");
    endtask

    task automatic t_shared();
        put(M_USR, 1'b0, 4'd3, 32'hA5A5_0003);
        look(M_FIQ, 1'b0, 4'd3, 32'hA5A5_0003, "R3 r3 from fiq");
        look(M_IRQ, 1'b0, 4'd3, 32'hA5A5_0003, "R3 r3 from irq");
        look(M_ABT, 1'b0, 4'd3, 32'hA5A5_0003, "R3 r3 from abt");
        look(M_SYS, 1'b0, 4'd3, 32'hA5A5_0003, "R3 r3 from sys");
        put(M_SVC, 1'b0, 4'd15, 32'h0000_8000);
        look(M_USR, 1'b0, 4'd15, 32'h0000_8000, "R3 r15 from user");
        look(M_FIQ, 1'b0, 4'd15, 32'h0000_8000, "R3 r15 from fiq");
        put(M_FIQ, 1'b0, 4'd0, 32'hF1F1_0000);
        look(M_UND, 1'b0, 4'd0, 32'hF1F1_0000, "R3 r0 from und");
    endtask

    task automatic t_fiq();
        for (int i = 8; i < 15; i++) put(M_USR, 1'b0, 4'(i), 32'h1000_0000 | i);
        for (int i = 8; i < 15; i++) put(M_FIQ, 1'b0, 4'(i), 32'h2000_0000 | i);
        for (int i = 8; i < 15; i++) look(M_FIQ, 1'b0, 4'(i), 32'h2000_0000 | i, "R4 fiq private");
        for (int i = 8; i < 15; i++) look(M_USR, 1'b0, 4'(i), 32'h1000_0000 | i, "R4 user untouched");
    endtask

    task automatic t_exc();
        for (int j = 1; j <= 4; j++) begin
            put(exc_mode(j), 1'b0, 4'd13, 32'h3000_000D | (j << 8));
            put(exc_mode(j), 1'b0, 4'd14, 32'h3000_000E | (j << 8));
        end
        for (int j = 1; j <= 4; j++) begin
            look(exc_mode(j), 1'b0, 4'd13, 32'h3000_000D | (j << 8), "R5 private r13");
            look(exc_mode(j), 1'b0, 4'd14, 32'h3000_000E | (j << 8), "R5 private r14");
        end
        look(M_USR, 1'b0, 4'd13, 32'h1000_000D, "R5 user r13 untouched");
        look(M_FIQ, 1'b0, 4'd14, 32'h2000_000E, "R5 fiq r14 untouched");
        look(M_IRQ, 1'b0, 4'd8,  32'h1000_0008, "R5 irq r8 is user copy");
        look(M_SVC, 1'b0, 4'd12, 32'h1000_000C, "R5 svc r12 is user copy");
        put(M_ABT, 1'b0, 4'd10, 32'hABAB_000A);
        look(M_USR, 1'b0, 4'd10, 32'hABAB_000A, "R5 abt r10 write reaches user");
        look(M_FIQ, 1'b0, 4'd10, 32'h2000_000A, "R5 fiq r10 untouched");
    endtask

    task automatic t_sys();
        look(M_SYS, 1'b0, 4'd13, 32'h1000_000D, "R6 sys r13 is user copy");
        look(M_SYS, 1'b0, 4'd9,  32'h1000_0009, "R6 sys r9 is user copy");
        put(M_SYS, 1'b0, 4'd14, 32'h5555_000E);
        look(M_USR, 1'b0, 4'd14, 32'h5555_000E, "R6 sys write reaches user");
        look(M_SVC, 1'b0, 4'd14, 32'h3000_020E, "R6 svc r14 untouched");
    endtask

    task automatic t_ovr();
        look(M_FIQ, 1'b1, 4'd9, 32'h1000_0009, "R7 fiq override reads user r9");
        look(M_IRQ, 1'b1, 4'd13, 32'h1000_000D, "R7 irq override reads user r13");
        put(M_SVC, 1'b1, 4'd13, 32'h6666_000D);
        look(M_USR, 1'b0, 4'd13, 32'h6666_000D, "R7 override write reaches user");
        look(M_SVC, 1'b0, 4'd13, 32'h3000_020D, "R7 svc r13 untouched by override");
        put(M_FIQ, 1'b1, 4'd8, 32'h7777_0008);
        look(M_USR, 1'b0, 4'd8, 32'h7777_0008, "R7 fiq override write reaches user");
        look(M_FIQ, 1'b0, 4'd8, 32'h2000_0008, "R7 fiq r8 untouched by override");
    endtask

    task automatic t_rdw();
        put(M_USR, 1'b0, 4'd5, 32'h0000_0505);
        @(negedge clk);
        mode = M_USR; ovr = 1'b0; ra = 4'd5; rb = 4'd5;
        widx = 4'd5; wdat = 32'hBEEF_0005; wen = 1'b1;
        #1;
        chk(rda, 32'h0000_0505, "R2 same-cycle read returns old value");
        @(negedge clk);
        wen = 1'b0;
        #1;
        chk(rda, 32'hBEEF_0005, "R2 write visible after edge");
        @(negedge clk);
        widx = 4'd5; wdat = 32'hDEAD_DEAD; wen = 1'b0;
        @(negedge clk);
        #1;
        chk(rdb, 32'hBEEF_0005, "R2 disabled write changes nothing");
    endtask

    task automatic t_sts();
        put_sts(M_FIQ, 1'b0, 32'hC000_0001);
        put_sts(M_IRQ, 1'b0, 32'hC000_0002);
        put_sts(M_SVC, 1'b0, 32'hC000_0003);
        put_sts(M_ABT, 1'b0, 32'hC000_0004);
        put_sts(M_UND, 1'b0, 32'hC000_0005);
        look_sts(M_FIQ, 1'b0, 32'hC000_0001, "R8 fiq status");
        look_sts(M_IRQ, 1'b0, 32'hC000_0002, "R8 irq status");
        look_sts(M_SVC, 1'b0, 32'hC000_0003, "R8 svc status");
        look_sts(M_ABT, 1'b0, 32'hC000_0004, "R8 abt status");
        look_sts(M_UND, 1'b0, 32'hC000_0005, "R8 und status");
        look_sts(M_USR, 1'b0, 32'h0, "R9 user status reads zero");
        look_sts(M_SYS, 1'b0, 32'h0, "R9 sys status reads zero");
        put_sts(M_USR, 1'b0, 32'hDEAD_0010);
        put_sts(M_SYS, 1'b0, 32'hDEAD_001F);
        look_sts(M_USR, 1'b0, 32'h0, "R9 user status still zero");
        look_sts(M_SYS, 1'b0, 32'h0, "R9 sys status still zero");
        look_sts(M_FIQ, 1'b0, 32'hC000_0001, "R9 fiq status kept");
        look_sts(M_IRQ, 1'b0, 32'hC000_0002, "R9 irq status kept");
        look_sts(M_UND, 1'b0, 32'hC000_0005, "R9 und status kept");
        put_sts(M_IRQ, 1'b1, 32'hC0DE_0002);
        look_sts(M_IRQ, 1'b0, 32'hC0DE_0002, "R8 override ignored on status write");
        look_sts(M_IRQ, 1'b1, 32'hC0DE_0002, "R8 override ignored on status read");
    endtask

    task automatic t_enc();
        look(5'b00000, 1'b0, 4'd13, 32'h6666_000D, "R10 unknown code uses user r13");
        look(5'b10100, 1'b0, 4'd8,  32'h7777_0008, "R10 unknown code uses user r8");
        look_sts(5'b10100, 1'b0, 32'h0, "R10 unknown code status zero");
        put_sts(5'b00000, 1'b0, 32'hBAD0_0000);
        look_sts(M_SVC, 1'b0, 32'hC000_0003, "R10 unknown code status write ignored");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared();
        t_fiq();
        t_exc();
        t_sys();
        t_ovr();
        t_rdw();
        t_sts();
        t_enc();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule